// File: doc/BRIEF.md
# Windowed Activity Monitor with Watermark Interrupts

This block counts activity on two independent channels and raises interrupts when that activity stays outside programmed limits. Each pulse on a channel's event input adds that channel's programmable weight to a window accumulator. A shared period timer counts millisecond tick pulses and closes a sample window every `P+1` ticks. At each close the block latches the window count, updates a per-channel exponential moving average, and compares both values against their own watermark pairs.

The raw count raises an interrupt only after a programmable number of consecutive windows have breached a watermark. The moving average raises its interrupt on the first window in which it lies beyond its own watermark. Status bits are sticky and are cleared by writing ones. They are collected into a global status word and a single registered interrupt line.

All setup and readback use a simple register bus. The bus has a one-cycle write strobe, and read data is registered one cycle after the read strobe. Address bits [7:6] select a region: 0 is global, 1 is channel 0, and 2 is channel 1. Address bits [5:0] select the register inside that region.

Top module: `actmon`

## Requirements
- R1: After reset every register reads zero, every status bit is clear and `irq` is low.
- R2: While a channel is enabled, every cycle with its event input high adds the weight register (channel offset 0x18) to its window accumulator. At window close the accumulated total can be read from offset 0x24.
- R3: The global period register (global offset 0x04, bits [7:0]) holds P, and a window closes on the (P+1)-th millisecond tick after the previous close.
- R4: At each close the average (read at offset 0x1C) becomes avg + ((count − avg) >>> (K+1)), computed as a signed value with K in control bits [12:10]. Writing offset 0x0C loads the average directly.
- R5: If the count exceeds the upper watermark (0x04) for N consecutive windows, status bit 31 is set. N is control bits [28:26] plus one, and the check is enabled by control bit 30. Any window without a breach restarts the run.
- R6: If the count is below the lower watermark (0x08) for N consecutive windows, status bit 30 is set. N is control bits [25:23] plus one, and the check is enabled by control bit 29.
- R7: If the new average exceeds the average-upper watermark (0x10), status bit 29 is set (enable: control bit 21). If it falls below the average-lower watermark (0x14), status bit 28 is set (enable: control bit 20).
- R8: Status bits (offset 0x20) are sticky. Writing a one to a status bit clears it.
- R9: Global status (global offset 0x00) bit 26 is set while channel 0 has any status bit set, and bit 25 is set while channel 1 has any status bit set. `irq` goes high one cycle after any status bit is set.
- R10: A channel runs only when control bit 31 (enable) and bit 18 (periodic) are both set. Writing zero to the control register (0x00) stops it: the accumulator is held at zero, and the average, the last count and the status bits no longer change at window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| event_in | input | 2 | Per-channel activity pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Registered OR of all pending status bits |

## Verification
The checker checks several properties on every cycle. A pending status bit must raise `irq` on the following cycle. The tick counter must restart after each window close. An idle channel must keep its accumulator at zero. A consecutive-breach status bit may appear only just after a window close. Only the bench scenarios can show the arithmetic: weighted sums, the arithmetic shift of a negative difference, and the effect of K. They also show the sequencing cases: breach runs restarted by a non-breaching window or an opposite breach, average seeding, clearing by writing ones, the exact tick that closes a window, and a stopped channel ignoring events.

// File: rtl/actmon_pkg.sv
package actmon_pkg;
  localparam int K_W   = 3;
  localparam int NUM_W = 3;

  // control register bit positions
  localparam int C_K_LSB      = 10;
  localparam int C_PERIODIC   = 18;
  localparam int C_AVG_LO_EN  = 20;
  localparam int C_AVG_HI_EN  = 21;
  localparam int C_LO_NUM_LSB = 23;
  localparam int C_HI_NUM_LSB = 26;
  localparam int C_LO_EN      = 29;
  localparam int C_HI_EN      = 30;
  localparam int C_ENB        = 31;

  // global status bit of channel 0; channel c uses GLB_BIT0 - c
  localparam int GLB_BIT0 = 26;

  // register offsets inside a region
  localparam logic [5:0] G_STAT   = 6'h00;
  localparam logic [5:0] G_PERIOD = 6'h04;
  localparam logic [5:0] R_CTRL   = 6'h00;
  localparam logic [5:0] R_UWM    = 6'h04;
  localparam logic [5:0] R_LWM    = 6'h08;
  localparam logic [5:0] R_SEED   = 6'h0C;
  localparam logic [5:0] R_AUWM   = 6'h10;
  localparam logic [5:0] R_ALWM   = 6'h14;
  localparam logic [5:0] R_WEIGHT = 6'h18;
  localparam logic [5:0] R_AVG    = 6'h1C;
  localparam logic [5:0] R_STAT   = 6'h20;
  localparam logic [5:0] R_LAST   = 6'h24;

  typedef struct packed {
    logic             enb;
    logic             periodic;
    logic             hi_en;
    logic             lo_en;
    logic             avg_hi_en;
    logic             avg_lo_en;
    logic [NUM_W-1:0] hi_num;
    logic [NUM_W-1:0] lo_num;
    logic [K_W-1:0]   k;
  } ch_cfg_t;
endpackage

// File: rtl/actmon_period_timer.sv
module actmon_period_timer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ms_tick,
  input  logic [PW-1:0] period,
  output logic          win_close,
  output logic [PW-1:0] tick_cnt
);
  assign win_close = ms_tick && (tick_cnt >= period);

  always_ff @(posedge clk) begin
    if (rst)
      tick_cnt <= '0;
    else if (ms_tick)
      tick_cnt <= win_close ? '0 : tick_cnt + 1'b1;
  end
endmodule

// File: rtl/actmon_channel.sv
module actmon_channel
  import actmon_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev,
  input  logic             win_close,
  input  ch_cfg_t          cfg,
  input  logic [DW-1:0]    up_wm,
  input  logic [DW-1:0]    lo_wm,
  input  logic [DW-1:0]    avg_up_wm,
  input  logic [DW-1:0]    avg_lo_wm,
  input  logic [DW-1:0]    weight,
  input  logic             seed_wr,
  input  logic [DW-1:0]    seed_val,
  input  logic [3:0]       clr_mask,
  output logic [DW-1:0]    avg,
  output logic [DW-1:0]    last_cnt,
  output logic [DW-1:0]    acc,
  output logic [3:0]       stat,
  output logic [NUM_W-1:0] hi_run,
  output logic [NUM_W-1:0] lo_run
);
  localparam int SW = DW + 2;

  logic                 active, close;
  logic [DW:0]          sum;
  logic [DW-1:0]        acc_inc;
  logic signed [SW-1:0] diff, step, avg_nxt;
  logic [K_W:0]         shamt;
  logic                 br_hi, br_lo, set_hi, set_lo, set_ahi, set_alo;
  logic [3:0]           set_vec;

  assign active  = cfg.enb && cfg.periodic;
  assign close   = win_close && active;
  assign sum     = {1'b0, acc} + {1'b0, weight};
  assign acc_inc = sum[DW] ? '1 : sum[DW-1:0];

  assign shamt   = {1'b0, cfg.k} + 1'b1;
  assign diff    = $signed({2'b00, acc}) - $signed({2'b00, avg});
  assign step    = diff >>> shamt;
  assign avg_nxt = $signed({2'b00, avg}) + step;

  assign br_hi   = acc > up_wm;
  assign br_lo   = acc < lo_wm;
  assign set_hi  = close && cfg.hi_en && br_hi && (hi_run >= cfg.hi_num);
  assign set_lo  = close && cfg.lo_en && br_lo && (lo_run >= cfg.lo_num);
  assign set_ahi = close && cfg.avg_hi_en && (avg_nxt > $signed({2'b00, avg_up_wm}));
  assign set_alo = close && cfg.avg_lo_en && (avg_nxt < $signed({2'b00, avg_lo_wm}));
  assign set_vec = {set_hi, set_lo, set_ahi, set_alo};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      avg      <= '0;
      last_cnt <= '0;
      stat     <= '0;
      hi_run   <= '0;
      lo_run   <= '0;
    end else begin
      if (!active)
        acc <= '0;
      else if (close)
        acc <= ev ? weight : '0;
      else if (ev)
        acc <= acc_inc;

      if (seed_wr)
        avg <= seed_val;
      else if (close)
        avg <= avg_nxt[DW-1:0];

      if (close)
        last_cnt <= acc;

      if (close && cfg.hi_en)
        hi_run <= (br_hi && !set_hi) ? hi_run + 1'b1 : '0;
      if (close && cfg.lo_en)
        lo_run <= (br_lo && !set_lo) ? lo_run + 1'b1 : '0;

      stat <= (stat & ~clr_mask) | set_vec;
    end
  end
endmodule

// File: rtl/actmon.sv
module actmon
  import actmon_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 32,
  parameter int AW  = 8,
  parameter int PW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ms_tick,
  input  logic [NCH-1:0] event_in,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           irq
);
  localparam int SELW = AW - 6;

  logic [SELW-1:0] sel;
  logic [5:0]      off;
  assign sel = bus_addr[AW-1:6];
  assign off = bus_addr[5:0];

  logic [PW-1:0] period_r;
  logic          win_close;
  logic [PW-1:0] tick_cnt;

  logic [DW-1:0] ctrl_r   [NCH];
  logic [DW-1:0] uwm_r    [NCH];
  logic [DW-1:0] lwm_r    [NCH];
  logic [DW-1:0] auwm_r   [NCH];
  logic [DW-1:0] alwm_r   [NCH];
  logic [DW-1:0] weight_r [NCH];
  logic [DW-1:0] avg      [NCH];
  logic [DW-1:0] last_cnt [NCH];
  logic [DW-1:0] acc      [NCH];
  logic [3:0]    stat     [NCH];
  logic [NUM_W-1:0] hi_run [NCH];
  logic [NUM_W-1:0] lo_run [NCH];
  ch_cfg_t       cfg      [NCH];
  logic [NCH-1:0] seed_wr, pend, ch_active;
  logic [3:0]    clr_mask [NCH];
  logic [DW-1:0] glb;
  logic [DW-1:0] rd_mux;

  actmon_period_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .period(period_r),
    .win_close(win_close), .tick_cnt(tick_cnt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [SELW-1:0] MYSEL = SELW'(c + 1);

    assign cfg[c].enb       = ctrl_r[c][C_ENB];
    assign cfg[c].periodic  = ctrl_r[c][C_PERIODIC];
    assign cfg[c].hi_en     = ctrl_r[c][C_HI_EN];
    assign cfg[c].lo_en     = ctrl_r[c][C_LO_EN];
    assign cfg[c].avg_hi_en = ctrl_r[c][C_AVG_HI_EN];
    assign cfg[c].avg_lo_en = ctrl_r[c][C_AVG_LO_EN];
    assign cfg[c].hi_num    = ctrl_r[c][C_HI_NUM_LSB +: NUM_W];
    assign cfg[c].lo_num    = ctrl_r[c][C_LO_NUM_LSB +: NUM_W];
    assign cfg[c].k         = ctrl_r[c][C_K_LSB +: K_W];
    assign ch_active[c]     = cfg[c].enb && cfg[c].periodic;

    assign seed_wr[c]  = bus_wr && (sel == MYSEL) && (off == R_SEED);
    assign clr_mask[c] = (bus_wr && (sel == MYSEL) && (off == R_STAT)) ?
                         bus_wdata[DW-1 -: 4] : 4'b0;
    assign pend[c]     = |stat[c];

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_r[c]   <= '0;
        uwm_r[c]    <= '0;
        lwm_r[c]    <= '0;
        auwm_r[c]   <= '0;
        alwm_r[c]   <= '0;
        weight_r[c] <= '0;
      end else if (bus_wr && (sel == MYSEL)) begin
        case (off)
          R_CTRL:   ctrl_r[c]   <= bus_wdata;
          R_UWM:    uwm_r[c]    <= bus_wdata;
          R_LWM:    lwm_r[c]    <= bus_wdata;
          R_AUWM:   auwm_r[c]   <= bus_wdata;
          R_ALWM:   alwm_r[c]   <= bus_wdata;
          R_WEIGHT: weight_r[c] <= bus_wdata;
          default: ;
        endcase
      end
    end

    actmon_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst(rst), .ev(event_in[c]), .win_close(win_close),
      .cfg(cfg[c]), .up_wm(uwm_r[c]), .lo_wm(lwm_r[c]),
      .avg_up_wm(auwm_r[c]), .avg_lo_wm(alwm_r[c]), .weight(weight_r[c]),
      .seed_wr(seed_wr[c]), .seed_val(bus_wdata), .clr_mask(clr_mask[c]),
      .avg(avg[c]), .last_cnt(last_cnt[c]), .acc(acc[c]), .stat(stat[c]),
      .hi_run(hi_run[c]), .lo_run(lo_run[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      period_r <= '0;
    else if (bus_wr && (sel == '0) && (off == G_PERIOD))
      period_r <= bus_wdata[PW-1:0];
  end

  always_comb begin
    glb = '0;
    for (int c = 0; c < NCH; c++)
      glb[GLB_BIT0 - c] = pend[c];
  end

  always_comb begin
    rd_mux = '0;
    if (sel == '0) begin
      case (off)
        G_STAT:   rd_mux = glb;
        G_PERIOD: rd_mux = DW'(period_r);
        default:  rd_mux = '0;
      endcase
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (sel == SELW'(c + 1)) begin
          case (off)
            R_CTRL:   rd_mux = ctrl_r[c];
            R_UWM:    rd_mux = uwm_r[c];
            R_LWM:    rd_mux = lwm_r[c];
            R_SEED:   rd_mux = avg[c];
            R_AUWM:   rd_mux = auwm_r[c];
            R_ALWM:   rd_mux = alwm_r[c];
            R_WEIGHT: rd_mux = weight_r[c];
            R_AVG:    rd_mux = avg[c];
            R_STAT:   rd_mux = {stat[c], {(DW-4){1'b0}}};
            R_LAST:   rd_mux = last_cnt[c];
            default:  rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd)
        bus_rdata <= rd_mux;
      irq <= |pend;
    end
  end
endmodule

module actmon_checker #(
  parameter int NCH = 2,
  parameter int DW  = 32,
  parameter int PW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           irq,
  input logic           win_close,
  input logic [PW-1:0]  tick_cnt,
  input logic [NCH-1:0] ch_active,
  input logic [NCH-1:0] pend,
  input logic [NCH*DW-1:0] acc_flat,
  input logic [NCH*4-1:0]  stat_flat
);
  // R9: a pending status bit drives irq on the following cycle
  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_flat != '0) |=> irq);

  // R3: the tick counter restarts after every window close
  assert_window_restart_R3: assert property (@(posedge clk) disable iff (rst)
    win_close |=> (tick_cnt == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R10: an idle channel keeps its accumulator empty
    assert_idle_acc_clear_R10: assert property (@(posedge clk) disable iff (rst)
      !ch_active[c] |=> (acc_flat[c*DW +: DW] == '0));

    // R5: a consecutive-upper flag appears only right after a window close
    assert_hi_flag_on_close_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(stat_flat[c*4 + 3]) |-> $past(win_close));

    // R6: a consecutive-lower flag appears only right after a window close
    assert_lo_flag_on_close_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(stat_flat[c*4 + 2]) |-> $past(win_close));

    // R9: global pending bit matches the channel's status word
    assert_pend_matches_R9: assert property (@(posedge clk) disable iff (rst)
      pend[c] == (stat_flat[c*4 +: 4] != 4'b0));
  end
endmodule

bind actmon actmon_checker #(.NCH(NCH), .DW(DW), .PW(PW)) u_actmon_checker (
  .clk(clk), .rst(rst), .irq(irq), .win_close(win_close), .tick_cnt(tick_cnt),
  .ch_active(ch_active), .pend(pend),
  .acc_flat({acc[1], acc[0]}),
  .stat_flat({stat[1], stat[0]})
);

// File: tb/test_actmon.sv
module test_actmon;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ms_tick = 1'b0;
  logic [1:0]  event_in = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [7:0] CH0 = 8'h40;
  localparam logic [7:0] CH1 = 8'h80;
  localparam int         P   = 3;

  always #4 clk = ~clk;

  actmon i_actmon (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .event_in(event_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // monitor: compare each read result against the scoreboard queue
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        #1;
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected read: actual %h expected none", bus_rdata);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (bus_rdata !== e) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_checks++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: actual irq=%b expected %b", t, irq, e);
    end
  endtask

  task automatic events(input int n0, input int n1);
    for (int i = 0; i < n0 || i < n1; i++) begin
      @(negedge clk);
      event_in = {(i < n1), (i < n0)};
    end
    @(negedge clk);
    event_in = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  endtask

  task automatic window(input int n0, input int n1);
    events(n0, n1);
    ticks(P + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd_exp(CH0 + 8'h00, 32'h0, "R1 ctrl reset");
    rd_exp(CH0 + 8'h1C, 32'h0, "R1 avg reset");
    rd_exp(CH0 + 8'h20, 32'h0, "R1 status reset");
    rd_exp(8'h00, 32'h0, "R1 global status reset");
    chk_irq(1'b0, "R1 irq reset");

    // setup channel 0
    wr(8'h04, P);
    wr(CH0 + 8'h18, 32'd4);
    wr(CH0 + 8'h04, 32'd40);
    wr(CH0 + 8'h08, 32'd10);
    wr(CH0 + 8'h10, 32'd100);
    wr(CH0 + 8'h14, 32'd5);
    wr(CH0 + 8'h0C, 32'd20);
    wr(CH0 + 8'h00, 32'hE434_0400);
    rd_exp(8'h04, P, "R3 period readback");
    rd_exp(CH0 + 8'h1C, 32'd20, "R4 seed average");

    // window 1: 12 events * 4 = 48; close only on the 4th tick
    events(12, 0);
    ticks(P);
    rd_exp(CH0 + 8'h24, 32'd0, "R3 no close before P+1 ticks");
    ticks(1);
    rd_exp(CH0 + 8'h24, 32'd48, "R2 window count");
    rd_exp(CH0 + 8'h1C, 32'd27, "R4 average after window 1");
    rd_exp(CH0 + 8'h20, 32'h0, "R5 single breach no flag");

    // window 2: 60, second consecutive breach
    window(15, 0);
    rd_exp(CH0 + 8'h20, 32'h8000_0000, "R5 two breaches flag");
    rd_exp(CH0 + 8'h1C, 32'd35, "R4 average after window 2");
    rd_exp(8'h00, 32'h0400_0000, "R9 global bit 26");
    chk_irq(1'b1, "R9 irq raised");
    wr(CH0 + 8'h20, 32'h8000_0000);
    rd_exp(CH0 + 8'h20, 32'h0, "R8 write-one clear");
    chk_irq(1'b0, "R9 irq dropped");

    // window 3: 8 < 10, below needs one window; negative step
    window(2, 0);
    rd_exp(CH0 + 8'h20, 32'h4000_0000, "R6 below flag");
    rd_exp(CH0 + 8'h1C, 32'd28, "R4 negative arithmetic shift");
    wr(CH0 + 8'h20, 32'h4000_0000);

    // window 4: 44 breach, run was restarted by window 3
    window(11, 0);
    rd_exp(CH0 + 8'h20, 32'h0, "R5 run restarted by lower breach");
    rd_exp(CH0 + 8'h1C, 32'd32, "R4 average after window 4");
    // window 5: 20, no breach
    window(5, 0);
    rd_exp(CH0 + 8'h1C, 32'd29, "R4 average after window 5");
    // window 6: 44, first of a new run only
    window(11, 0);
    rd_exp(CH0 + 8'h20, 32'h0, "R5 run restarted by quiet window");

    // seed then average-above
    wr(CH0 + 8'h0C, 32'd200);
    rd_exp(CH0 + 8'h1C, 32'd200, "R4 reseed");
    window(6, 0);
    rd_exp(CH0 + 8'h1C, 32'd156, "R4 average from seed");
    rd_exp(CH0 + 8'h20, 32'h2000_0000, "R7 average above flag");
    wr(CH0 + 8'h20, 32'hF000_0000);

    // stop channel 0
    wr(CH0 + 8'h00, 32'h0);
    window(30, 0);
    rd_exp(CH0 + 8'h24, 32'd24, "R10 stopped count held");
    rd_exp(CH0 + 8'h1C, 32'd156, "R10 stopped average held");
    rd_exp(CH0 + 8'h20, 32'h0, "R10 stopped no status");

    // channel 1: K=0, average-below only
    wr(CH1 + 8'h18, 32'd16);
    wr(CH1 + 8'h14, 32'd50);
    wr(CH1 + 8'h10, 32'hFFFF_FFFF);
    wr(CH1 + 8'h0C, 32'd100);
    wr(CH1 + 8'h00, 32'h8014_0000);
    window(0, 2);
    rd_exp(CH1 + 8'h24, 32'd32, "R2 channel 1 weight");
    rd_exp(CH1 + 8'h1C, 32'd66, "R4 channel 1 K=0");
    rd_exp(CH1 + 8'h20, 32'h0, "R7 average not yet below");
    window(0, 0);
    rd_exp(CH1 + 8'h1C, 32'd33, "R4 channel 1 empty window");
    rd_exp(CH1 + 8'h20, 32'h1000_0000, "R7 average below flag");
    rd_exp(8'h00, 32'h0200_0000, "R9 global bit 25");
    chk_irq(1'b1, "R9 irq from channel 1");
    wr(CH1 + 8'h20, 32'h1000_0000);
    rd_exp(8'h00, 32'h0, "R8 global clear after W1C");
    chk_irq(1'b0, "R9 irq cleared");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule